// File: doc/BRIEF.md
# PCIe Message Request Receive Checker

This block sits on the receive side of a PCIe transaction layer and judges one Message request header per cycle. The header fields arrive in parallel with a valid flag, together with the first payload doubleword and a flag telling whether the receiving port faces downstream. One cycle later the block raises exactly one of four verdict strobes: accept, silent drop, Malformed TLP, or Unsupported Request. It also reports the decoded message class and the captured attribute bits.

The checks depend on the message class. Every class except vendor-defined must use traffic class 0. Classes that carry no payload must use the no-data format, and their Length field is ignored. The slot power limit message must carry exactly one data doubleword whose upper 22 bits are zero. INTx messages that arrive on an upstream-facing port can be rejected; a parameter enables this check. A vendor-defined message whose vendor ID is not recognised is handled by its type: type 1 is dropped silently and type 0 is reported as Unsupported Request. Routing, forwarding and any use of the payload belong to other blocks.

Top module: `pcie_msg_rx_check`

## Requirements
- R1: For every cycle with `hdrValid` high, exactly one of `acceptStb`, `dropStb`, `malformedStb`, `urStb` is high in the following cycle. In a cycle that follows a cycle with `hdrValid` low, all four strobes are low.
- R2: A message of any known class other than vendor-defined with `hdrTc` not equal to 0 is reported as Malformed. Vendor-defined messages accept any TC value.
- R3: INTx, power management, error, unlock, LTR and OBFF messages with Fmt 3'b011 (4DW with data) are reported as Malformed. Their `hdrLength` value has no effect on the verdict.
- R4: A slot power limit message (code 0x50) is accepted only with Fmt 3'b011, `hdrLength` equal to 1 and `payloadDw[31:10]` all zero. Any other combination is Malformed. `payloadDw[9:0]` may take any value.
- R5: When the parameter `INTX_DIR_CHECK` is 1, an INTx message (codes 0x20 to 0x27) received with `isDownPort` low is reported as Malformed.
- R6: A vendor-defined message (0x7E is type 0, 0x7F is type 1) whose `hdrVendorId` differs from the parameter `OWN_VENDOR_ID` is dropped when it is type 1 and reported as Unsupported Request when it is type 0. With a matching vendor ID it is accepted. `attrOut` shows the `hdrAttr` bits of the last valid header.
- R7: A header is a message when `hdrFmt[2]` is 0 and `hdrType[4:3]` is 2'b10. A header that is not a message is reported as Unsupported Request. So is a message whose code belongs to no known class.
- R8: A message that uses a 3DW format (`hdrFmt[0]` equal to 0) is reported as Malformed, whatever its code.
- R9: When several faults apply, Malformed wins over Unsupported Request, and Unsupported Request wins over silent drop.
- R10: `msgClass` reports the class of the last valid header: 0 none or unknown, 1 INTx (0x20 to 0x27), 2 power management (0x14, 0x18, 0x19, 0x1B), 3 error (0x30, 0x31, 0x33), 4 unlock (0x00), 5 slot power limit (0x50), 6 vendor type 0, 7 vendor type 1, 8 LTR (0x10), 9 OBFF (0x12). It holds its value while `hdrValid` is low.
- R11: While `rstN` is low, all strobes are low and `msgClass` and `attrOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Header fields are valid this cycle |
| hdrFmt | input | 3 | Format field |
| hdrType | input | 5 | Type field including the routing subfield |
| hdrTc | input | 3 | Traffic class |
| hdrAttr | input | 3 | Attribute bits |
| hdrLength | input | 10 | Length field in doublewords |
| hdrMsgCode | input | 8 | Message code |
| hdrVendorId | input | 16 | Vendor ID for vendor-defined messages |
| payloadDw | input | 32 | First payload doubleword |
| isDownPort | input | 1 | Receiving port faces downstream |
| acceptStb | output | 1 | Header accepted |
| dropStb | output | 1 | Header silently discarded |
| malformedStb | output | 1 | Malformed TLP error |
| urStb | output | 1 | Unsupported Request error |
| msgClass | output | 4 | Decoded class of the last valid header |
| attrOut | output | 3 | Attribute bits of the last valid header |

## Verification
Each header is judged on its own in a single cycle, so a wrong decode or a wrong check shows up on the strobes in the very next cycle, as the wrong verdict, as two strobes at once, or as no strobe. The only stored state is the class and attribute capture. A fault in that capture shows on `msgClass` or `attrOut` after the next valid header, or as a value that changes during idle cycles. The stimulus sends headers back to back, so a strobe that is late or too long would land on the next verdict. It also crosses faults so that each step of the priority order is decided on its own.

// File: rtl/pcie_msg_pkg.sv
package pcie_msg_pkg;

  localparam int FMT_W     = 3;
  localparam int TYPE_W    = 5;
  localparam int TC_W      = 3;
  localparam int ATTR_W    = 3;
  localparam int LEN_W     = 10;
  localparam int CODE_W    = 8;
  localparam int VID_W     = 16;
  localparam int DW_W      = 32;
  localparam int PWR_BITS  = 10;
  localparam int CLASS_W   = 4;

  typedef enum logic [CLASS_W-1:0] {
    MC_NONE   = 4'd0,
    MC_INTX   = 4'd1,
    MC_PM     = 4'd2,
    MC_ERR    = 4'd3,
    MC_UNLOCK = 4'd4,
    MC_SSPL   = 4'd5,
    MC_VDM0   = 4'd6,
    MC_VDM1   = 4'd7,
    MC_LTR    = 4'd8,
    MC_OBFF   = 4'd9
  } msg_class_e;

  // fault flags, datapath -> control
  typedef struct packed {
    logic isMsg;
    logic known;
    logic shortFmt;
    logic tcBad;
    logic fmtBad;
    logic payloadBad;
    logic dirBad;
    logic vendorMiss;
    logic vendorT1;
  } chk_flags_t;

  // strobes, control -> datapath
  typedef struct packed {
    logic capture;
  } ctl_strb_t;

  function automatic msg_class_e classifyCode(input logic [CODE_W-1:0] code);
    msg_class_e c;
    case (code) inside
      [8'h20:8'h27]:                 c = MC_INTX;
      8'h14, 8'h18, 8'h19, 8'h1B:    c = MC_PM;
      8'h30, 8'h31, 8'h33:           c = MC_ERR;
      8'h00:                         c = MC_UNLOCK;
      8'h50:                         c = MC_SSPL;
      8'h7E:                         c = MC_VDM0;
      8'h7F:                         c = MC_VDM1;
      8'h10:                         c = MC_LTR;
      8'h12:                         c = MC_OBFF;
      default:                       c = MC_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/msg_hdr_datapath.sv
module msg_hdr_datapath
  import pcie_msg_pkg::*;
#(
  parameter logic [VID_W-1:0] OWN_VENDOR_ID  = 16'h1ABC,
  parameter bit               INTX_DIR_CHECK = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [FMT_W-1:0]    hdrFmt,
  input  logic [TYPE_W-1:0]   hdrType,
  input  logic [TC_W-1:0]     hdrTc,
  input  logic [ATTR_W-1:0]   hdrAttr,
  input  logic [LEN_W-1:0]    hdrLength,
  input  logic [CODE_W-1:0]   hdrMsgCode,
  input  logic [VID_W-1:0]    hdrVendorId,
  input  logic [DW_W-1:0]     payloadDw,
  input  logic                isDownPort,
  input  ctl_strb_t           ctl,
  output chk_flags_t          flags,
  output msg_class_e          decClass,
  output msg_class_e          classQ,
  output logic [ATTR_W-1:0]   attrQ
);

  localparam logic [1:0]       MSG_TYPE_HI = 2'b10;
  localparam logic [LEN_W-1:0] SSPL_LEN    = LEN_W'(1);

  logic hasData;
  logic isVendor;
  logic noPayloadCls;
  logic dirFault;
  logic unusedBits;

  assign unusedBits = ^{payloadDw[PWR_BITS-1:0], hdrType[TYPE_W-3:0]};

  assign hasData = hdrFmt[1];

  always_comb begin
    flags       = '0;
    flags.isMsg = !hdrFmt[2] && (hdrType[TYPE_W-1:TYPE_W-2] == MSG_TYPE_HI);
    decClass    = flags.isMsg ? classifyCode(hdrMsgCode) : MC_NONE;
    isVendor    = (decClass == MC_VDM0) || (decClass == MC_VDM1);
    noPayloadCls = (decClass == MC_INTX) || (decClass == MC_PM) ||
                   (decClass == MC_ERR) || (decClass == MC_UNLOCK) ||
                   (decClass == MC_LTR) || (decClass == MC_OBFF);
    flags.known      = (decClass != MC_NONE);
    flags.shortFmt   = flags.isMsg && !hdrFmt[0];
    flags.tcBad      = flags.known && !isVendor && (hdrTc != '0);
    flags.fmtBad     = (noPayloadCls && hasData) ||
                       ((decClass == MC_SSPL) && !hasData);
    flags.payloadBad = (decClass == MC_SSPL) &&
                       ((hdrLength != SSPL_LEN) ||
                        (payloadDw[DW_W-1:PWR_BITS] != '0));
    flags.dirBad     = dirFault;
    flags.vendorMiss = isVendor && (hdrVendorId != OWN_VENDOR_ID);
    flags.vendorT1   = (decClass == MC_VDM1);
  end

  generate
    if (INTX_DIR_CHECK) begin : g_dirChk
      assign dirFault = (decClass == MC_INTX) && !isDownPort;
    end else begin : g_noDirChk
      logic unusedDir;
      assign unusedDir = isDownPort;
      assign dirFault  = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      classQ <= MC_NONE;
      attrQ  <= '0;
    end else if (ctl.capture) begin
      classQ <= decClass;
      attrQ  <= hdrAttr;
    end
  end

  // R10: class capture holds while no header is presented
  assert_class_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(classQ) && $stable(attrQ));

  // R6: vendor ID mismatch is only ever raised for vendor classes
  assert_vendor_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    flags.vendorMiss |-> (hdrMsgCode inside {8'h7E, 8'h7F}) && flags.isMsg);

endmodule

// File: rtl/msg_verdict_ctrl.sv
module msg_verdict_ctrl
  import pcie_msg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hdrValid,
  input  chk_flags_t flags,
  output ctl_strb_t  ctl,
  output logic       acceptStb,
  output logic       dropStb,
  output logic       malformedStb,
  output logic       urStb
);

  typedef enum logic [1:0] {V_ACCEPT, V_DROP, V_MAL, V_UR} verdict_e;

  logic     malHit;
  logic     urHit;
  logic     dropHit;
  verdict_e verdict;

  always_comb begin
    malHit  = flags.isMsg && (flags.shortFmt || flags.tcBad || flags.fmtBad ||
                              flags.payloadBad || flags.dirBad);
    urHit   = !flags.isMsg || !flags.known ||
              (flags.vendorMiss && !flags.vendorT1);
    dropHit = flags.vendorMiss && flags.vendorT1;
    if (malHit)       verdict = V_MAL;
    else if (urHit)   verdict = V_UR;
    else if (dropHit) verdict = V_DROP;
    else              verdict = V_ACCEPT;
    ctl.capture = hdrValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptStb    <= 1'b0;
      dropStb      <= 1'b0;
      malformedStb <= 1'b0;
      urStb        <= 1'b0;
    end else begin
      acceptStb    <= hdrValid && (verdict == V_ACCEPT);
      dropStb      <= hdrValid && (verdict == V_DROP);
      malformedStb <= hdrValid && (verdict == V_MAL);
      urStb        <= hdrValid && (verdict == V_UR);
    end
  end

  assert_one_result_R1: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> $countones({acceptStb, dropStb, malformedStb, urStb}) == 1);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> !(acceptStb || dropStb || malformedStb || urStb));

  // R8 and R9: a 3DW message is Malformed even if other faults apply
  assert_short_fmt_R8: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && flags.shortFmt |=> malformedStb);

endmodule

// File: rtl/pcie_msg_rx_check.sv
module pcie_msg_rx_check
  import pcie_msg_pkg::*;
#(
  parameter logic [15:0] OWN_VENDOR_ID  = 16'h1ABC,
  parameter bit          INTX_DIR_CHECK = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hdrValid,
  input  logic [2:0]  hdrFmt,
  input  logic [4:0]  hdrType,
  input  logic [2:0]  hdrTc,
  input  logic [2:0]  hdrAttr,
  input  logic [9:0]  hdrLength,
  input  logic [7:0]  hdrMsgCode,
  input  logic [15:0] hdrVendorId,
  input  logic [31:0] payloadDw,
  input  logic        isDownPort,
  output logic        acceptStb,
  output logic        dropStb,
  output logic        malformedStb,
  output logic        urStb,
  output logic [3:0]  msgClass,
  output logic [2:0]  attrOut
);

  chk_flags_t flags;
  ctl_strb_t  ctl;
  msg_class_e decClass;
  msg_class_e classQ;

  msg_hdr_datapath #(
    .OWN_VENDOR_ID (OWN_VENDOR_ID),
    .INTX_DIR_CHECK(INTX_DIR_CHECK)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .hdrFmt     (hdrFmt),
    .hdrType    (hdrType),
    .hdrTc      (hdrTc),
    .hdrAttr    (hdrAttr),
    .hdrLength  (hdrLength),
    .hdrMsgCode (hdrMsgCode),
    .hdrVendorId(hdrVendorId),
    .payloadDw  (payloadDw),
    .isDownPort (isDownPort),
    .ctl        (ctl),
    .flags      (flags),
    .decClass   (decClass),
    .classQ     (classQ),
    .attrQ      (attrOut)
  );

  msg_verdict_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .hdrValid    (hdrValid),
    .flags       (flags),
    .ctl         (ctl),
    .acceptStb   (acceptStb),
    .dropStb     (dropStb),
    .malformedStb(malformedStb),
    .urStb       (urStb)
  );

  assign msgClass = classQ;

  // R2: nonzero TC on a non-vendor known class is Malformed
  assert_tc_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && (hdrTc != 3'd0) && (decClass != MC_NONE) &&
    (decClass != MC_VDM0) && (decClass != MC_VDM1) |=> malformedStb);

  // R4: slot power limit with upper payload bits set is Malformed
  assert_sspl_payload_R4: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && (decClass == MC_SSPL) && (payloadDw[31:10] != '0)
    |=> malformedStb && (msgClass == 4'd5));

  // R6: unknown vendor type 1 on a well-formed 4DW header is dropped
  assert_vdm1_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && (decClass == MC_VDM1) && hdrFmt[0] &&
    (hdrVendorId != OWN_VENDOR_ID) |=> dropStb);

  // R7: non-message header is Unsupported Request
  assert_non_msg_ur_R7: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && (hdrFmt[2] || (hdrType[4:3] != 2'b10)) |=> urStb);

endmodule

// File: tb/pcie_msg_rx_check_tb_top.sv
module pcie_msg_rx_check_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VID = 16'h1ABC;
  localparam logic [15:0] XID = 16'h0BAD;

  // result codes: 0 accept, 1 drop, 2 malformed, 3 UR
  typedef struct packed {
    logic [2:0]  fmt;
    logic [4:0]  typ;
    logic [2:0]  tc;
    logic [2:0]  attr;
    logic [9:0]  len;
    logic [7:0]  code;
    logic [15:0] vid;
    logic [31:0] pay;
    logic        down;
    logic [1:0]  res;
    logic [3:0]  cls;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{3'b001, 5'b10100, 3'd0, 3'd0, 10'd0, 8'h20, 16'h0, 32'h0, 1'b1, 2'd0, 4'd1, 4'd10}, // R10 INTA
    '{3'b001, 5'b10100, 3'd0, 3'd0, 10'd0, 8'h21, 16'h0, 32'h0, 1'b0, 2'd2, 4'd1, 4'd5},  // R5 up port
    '{3'b001, 5'b10100, 3'd1, 3'd0, 10'd0, 8'h22, 16'h0, 32'h0, 1'b1, 2'd2, 4'd1, 4'd2},  // R2
    '{3'b001, 5'b10000, 3'd0, 3'd2, 10'd5, 8'h18, 16'h0, 32'h0, 1'b1, 2'd0, 4'd2, 4'd3},  // R3 length ignored
    '{3'b011, 5'b10011, 3'd0, 3'd0, 10'd1, 8'h19, 16'h0, 32'h0, 1'b0, 2'd2, 4'd2, 4'd3},  // R3 data fmt
    '{3'b001, 5'b10000, 3'd0, 3'd0, 10'd0, 8'h33, 16'h0, 32'h0, 1'b1, 2'd0, 4'd3, 4'd10}, // R10 ERR
    '{3'b001, 5'b10011, 3'd2, 3'd0, 10'd0, 8'h00, 16'h0, 32'h0, 1'b0, 2'd2, 4'd4, 4'd2},  // R2 unlock
    '{3'b011, 5'b10100, 3'd0, 3'd0, 10'd1, 8'h50, 16'h0, 32'h3FF, 1'b0, 2'd0, 4'd5, 4'd4}, // R4 ok
    '{3'b011, 5'b10100, 3'd0, 3'd0, 10'd1, 8'h50, 16'h0, 32'h400, 1'b0, 2'd2, 4'd5, 4'd4}, // R4 upper bit
    '{3'b011, 5'b10100, 3'd0, 3'd0, 10'd2, 8'h50, 16'h0, 32'h1, 1'b0, 2'd2, 4'd5, 4'd4},  // R4 length
    '{3'b001, 5'b10100, 3'd0, 3'd0, 10'd1, 8'h50, 16'h0, 32'h1, 1'b0, 2'd2, 4'd5, 4'd4},  // R4 no data
    '{3'b001, 5'b10010, 3'd3, 3'd0, 10'd0, 8'h7E, XID, 32'h0, 1'b1, 2'd3, 4'd6, 4'd6},   // R6 vdm0 miss
    '{3'b001, 5'b10010, 3'd0, 3'd0, 10'd0, 8'h7F, XID, 32'h0, 1'b1, 2'd1, 4'd7, 4'd6},   // R6 vdm1 miss
    '{3'b011, 5'b10010, 3'd5, 3'd5, 10'd1, 8'h7F, VID, 32'hFFFF_FFFF, 1'b1, 2'd0, 4'd7, 4'd6}, // R6 hit
    '{3'b001, 5'b10100, 3'd0, 3'd0, 10'd0, 8'h10, 16'h0, 32'h0, 1'b0, 2'd0, 4'd8, 4'd10}, // R10 LTR
    '{3'b001, 5'b10100, 3'd7, 3'd0, 10'd0, 8'h12, 16'h0, 32'h0, 1'b0, 2'd2, 4'd9, 4'd2},  // R2 OBFF
    '{3'b001, 5'b10100, 3'd0, 3'd0, 10'd0, 8'h55, 16'h0, 32'h0, 1'b0, 2'd3, 4'd0, 4'd7},  // R7 unknown code
    '{3'b000, 5'b00000, 3'd0, 3'd0, 10'd1, 8'h00, 16'h0, 32'h0, 1'b0, 2'd3, 4'd0, 4'd7},  // R7 mem read
    '{3'b000, 5'b10100, 3'd0, 3'd0, 10'd0, 8'h55, 16'h0, 32'h0, 1'b0, 2'd2, 4'd0, 4'd9},  // R9 mal over UR
    '{3'b000, 5'b10010, 3'd0, 3'd0, 10'd0, 8'h7E, XID, 32'h0, 1'b1, 2'd2, 4'd6, 4'd8},   // R8 3DW vendor
    '{3'b001, 5'b10101, 3'd0, 3'd0, 10'd0, 8'h1B, 16'h0, 32'h0, 1'b1, 2'd0, 4'd2, 4'd10}, // R10 PME ack
    '{3'b001, 5'b10100, 3'd0, 3'd1, 10'd3, 8'h27, 16'h0, 32'h0, 1'b1, 2'd0, 4'd1, 4'd3}   // R3 deassert D
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdrValid = 1'b0;
  logic [2:0] hdrFmt = '0;
  logic [4:0] hdrType = '0;
  logic [2:0] hdrTc = '0;
  logic [2:0] hdrAttr = '0;
  logic [9:0] hdrLength = '0;
  logic [7:0] hdrMsgCode = '0;
  logic [15:0] hdrVendorId = '0;
  logic [31:0] payloadDw = '0;
  logic isDownPort = 1'b0;
  logic acceptStb, dropStb, malformedStb, urStb;
  logic [3:0] msgClass;
  logic [2:0] attrOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcie_msg_rx_check #(.OWN_VENDOR_ID(VID), .INTX_DIR_CHECK(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrFmt(hdrFmt),
    .hdrType(hdrType), .hdrTc(hdrTc), .hdrAttr(hdrAttr),
    .hdrLength(hdrLength), .hdrMsgCode(hdrMsgCode),
    .hdrVendorId(hdrVendorId), .payloadDw(payloadDw),
    .isDownPort(isDownPort), .acceptStb(acceptStb), .dropStb(dropStb),
    .malformedStb(malformedStb), .urStb(urStb), .msgClass(msgClass),
    .attrOut(attrOut)
  );

  function automatic int resultCode();
    int n = int'(acceptStb) + int'(dropStb) + int'(malformedStb) + int'(urStb);
    if (n == 0) return 8;
    if (n > 1) return 9;
    if (acceptStb) return 0;
    if (dropStb) return 1;
    if (malformedStb) return 2;
    return 3;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    hdrValid = 1'b1; hdrFmt = v.fmt; hdrType = v.typ; hdrTc = v.tc;
    hdrAttr = v.attr; hdrLength = v.len; hdrMsgCode = v.code;
    hdrVendorId = v.vid; payloadDw = v.pay; isDownPort = v.down;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog act=hung exp=done");
    finishRun();
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11", "strobes in reset", resultCode(), 8);
    check("R11", "class in reset", int'(msgClass), 0);
    check("R11", "attr in reset", int'(attrOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", resultCode(), 8);

    // table, headers back to back
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d", VEC[i].req), $sformatf("verdict vec %0d", i),
            resultCode(), int'(VEC[i].res));
      check("R10", $sformatf("class vec %0d", i), int'(msgClass), int'(VEC[i].cls));
      check("R6", $sformatf("attr vec %0d", i), int'(attrOut), int'(VEC[i].attr));
    end

    // R1 / R10: idle cycle gives no strobe and holds class and attr
    hdrValid = 1'b0;
    hdrMsgCode = 8'h50; hdrAttr = 3'd6;
    @(negedge clk);
    check("R1", "no strobe when idle", resultCode(), 8);
    check("R10", "class held idle", int'(msgClass), 1);
    check("R10", "attr held idle", int'(attrOut), 1);
    @(negedge clk);
    check("R10", "class held 2nd idle", int'(msgClass), 1);

    // R9: unknown vendor type 0 with TC set and matching nothing -> UR not drop
    drive('{3'b011, 5'b10010, 3'd4, 3'd3, 10'd2, 8'h7E, XID, 32'h0, 1'b0, 2'd3, 4'd6, 4'd9});
    @(negedge clk);
    check("R9", "UR wins for vdm0", resultCode(), 3);

    // R5: INTx on downstream-facing port accepted
    drive('{3'b001, 5'b10100, 3'd0, 3'd0, 10'd0, 8'h24, 16'h0, 32'h0, 1'b1, 2'd0, 4'd1, 4'd5});
    @(negedge clk);
    check("R5", "intx down port", resultCode(), 0);

    // R11: reset while traffic active clears outputs
    drive(VEC[13]);
    rstN = 1'b0;
    @(negedge clk);
    check("R11", "strobes after mid reset", resultCode(), 8);
    check("R11", "class after mid reset", int'(msgClass), 0);
    check("R11", "attr after mid reset", int'(attrOut), 0);
    hdrValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "quiet after reset release", resultCode(), 8);

    finishRun();
  end

endmodule